// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional Atomics

This block sits beside one processor's data cache and tracks a single atomic reservation. A load-linked request records the cache line it touched and marks the reservation live. A later store-conditional consults that record. If the reservation is still live and the store targets the same line, the block enables the store towards the cache and returns the value 1 for the processor's result register. Otherwise it suppresses the store and returns 0.

The reservation is dropped by three events:
- a coherence invalidation that names the reserved line;
- the cache evicting that line;
- a context switch, whatever line is involved.

Every store-conditional also consumes the reservation, whether it succeeds or fails. The store enable, store address, store data and result are registered and appear one clock after the store-conditional request. The cache array and the lock software that uses the primitive lie outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `st_en_o` and `result_valid_o` are 0 and no reservation exists, so a store-conditional issued straight after reset fails.
- R2: A store-conditional to the reserved line produces the following one clock after the request: `st_en_o`=1, `result_valid_o`=1 and `result_o`=1. `st_addr_o` and `st_data_o` carry that request's address and data.
- R3: A store-conditional with no live reservation, or to a line other than the reserved one, produces `st_en_o`=0, `result_valid_o`=1 and `result_o`=0 one clock later.
- R4: Lines are 2**LINE_OFF_W bytes (16 by default), and the comparison uses only address bits above bit LINE_OFF_W-1. A store-conditional to another byte offset in the reserved line succeeds.
- R5: Every store-conditional clears the reservation, so an immediately repeated store-conditional to the same line fails. This holds even when the first one failed.
- R6: A new load-linked replaces any existing reservation with the new line. A store-conditional to the old line then fails, and one to the new line succeeds.
- R7: An invalidation (`inv_valid_i`) whose address lies in the reserved line clears the reservation. An invalidation to any other line leaves it intact.
- R8: An eviction (`evict_valid_i`) whose address lies in the reserved line clears the reservation. An eviction of any other line leaves it intact.
- R9: A context-switch pulse clears the reservation regardless of address. This includes a pulse in the same cycle as a store-conditional, which then fails.
- R10: An invalidation of the reserved line in the same cycle as a store-conditional to that line makes the store-conditional fail.
- R11: An invalidation or eviction that hits the line of a load-linked in the same cycle leaves no reservation. A cancel event to another line does not disturb the new reservation.
- R12: `req_op_i` selects the request: 0 for load-linked, 1 for store-conditional. `result_valid_o` is high exactly one cycle after each store-conditional request and low otherwise. `st_en_o` is never high without `result_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request strobe |
| req_op_i | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_data_i | input | DATA_W | Store data of a store-conditional |
| inv_valid_i | input | 1 | Snooped invalidation strobe |
| inv_addr_i | input | ADDR_W | Address of the invalidated line |
| evict_valid_i | input | 1 | Local eviction strobe |
| evict_addr_i | input | ADDR_W | Address of the evicted line |
| ctx_switch_i | input | 1 | Context-switch pulse |
| st_en_o | output | 1 | Store enable to the cache |
| st_addr_o | output | ADDR_W | Store address |
| st_data_o | output | DATA_W | Store data |
| result_valid_o | output | 1 | Result write-back strobe |
| result_o | output | DATA_W | 1 on success, 0 on failure |

## Verification
The hardest situations to reach are the same-cycle races. In one, a cancel event lands in the very cycle that a store-conditional or load-linked needs the reservation. In the other, a cancel event names a line that differs from the reserved one only in its offset bits. The vector table drives the cancel inputs together with the request in a single cycle, with offsets chosen inside and just outside the reserved line. Each race is paired with a control vector whose cancel address falls in a neighbouring line, so a comparator that drops or widens the tag is exposed. A mid-run reset after a load-linked shows that reset alone kills a live reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam logic OP_LL = 1'b0;
  localparam logic OP_SC = 1'b1;

  // address-matched cancel sources
  typedef enum int unsigned {
    KSRC_INV   = 0,
    KSRC_EVICT = 1,
    KSRC_NUM   = 2
  } ksrc_e;
endpackage

// File: rtl/llsc_line_cmp.sv
module llsc_line_cmp #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_OFF_W = 4,
  localparam int unsigned TAG_W     = ADDR_W - LINE_OFF_W
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o
);
  assign hit_o = en_i && (addr_i[ADDR_W-1:LINE_OFF_W] == tag_i);
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int unsigned TAG_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ll_i,
  input  logic             sc_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             kill_i,
  output logic             resv_valid_o,
  output logic [TAG_W-1:0] resv_tag_o,
  output logic [TAG_W-1:0] cand_tag_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic             cand_valid;

  // a load-linked presents its line to the cancel comparators in the same cycle
  assign cand_tag_o = ll_i ? req_tag_i : tag_q;
  assign cand_valid = ll_i || valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= cand_valid && !kill_i && !sc_i;
      tag_q   <= cand_tag_o;
    end
  end

  assign resv_valid_o = valid_q;
  assign resv_tag_o   = tag_q;
endmodule

// File: rtl/llsc_sc_resp.sv
module llsc_sc_resp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sc_i,
  input  logic              ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              st_en_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_en_o        <= 1'b0;
      st_addr_o      <= '0;
      st_data_o      <= '0;
      result_valid_o <= 1'b0;
      result_o       <= '0;
    end else begin
      st_en_o        <= sc_i && ok_i;
      result_valid_o <= sc_i;
      if (sc_i) begin
        st_addr_o <= addr_i;
        st_data_o <= data_i;
        result_o  <= DATA_W'(ok_i);
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_OFF_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic              ctx_switch_i,
  output logic              st_en_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned TAG_W = ADDR_W - LINE_OFF_W;
  localparam int unsigned NSRC  = KSRC_NUM;

  logic             is_ll, is_sc;
  logic [TAG_W-1:0] req_tag, resv_tag, cand_tag;
  logic             resv_valid;
  logic             kill, sc_ok;
  logic [NSRC-1:0]  src_en, src_hit;
  logic [ADDR_W-1:0] src_addr [NSRC];

  assign is_ll   = req_valid_i && (req_op_i == OP_LL);
  assign is_sc   = req_valid_i && (req_op_i == OP_SC);
  assign req_tag = req_addr_i[ADDR_W-1:LINE_OFF_W];

  assign src_en[KSRC_INV]     = inv_valid_i;
  assign src_addr[KSRC_INV]   = inv_addr_i;
  assign src_en[KSRC_EVICT]   = evict_valid_i;
  assign src_addr[KSRC_EVICT] = evict_addr_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_kill
    llsc_line_cmp #(
      .ADDR_W    (ADDR_W),
      .LINE_OFF_W(LINE_OFF_W)
    ) u_cmp (
      .en_i  (src_en[g]),
      .addr_i(src_addr[g]),
      .tag_i (cand_tag),
      .hit_o (src_hit[g])
    );
  end

  // cancel events win over a same-cycle request
  assign kill  = (|src_hit) || ctx_switch_i;
  assign sc_ok = resv_valid && (req_tag == resv_tag) && !kill;

  llsc_resv_reg #(
    .TAG_W(TAG_W)
  ) u_resv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ll_i        (is_ll),
    .sc_i        (is_sc),
    .req_tag_i   (req_tag),
    .kill_i      (kill),
    .resv_valid_o(resv_valid),
    .resv_tag_o  (resv_tag),
    .cand_tag_o  (cand_tag)
  );

  llsc_sc_resp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_resp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sc_i          (is_sc),
    .ok_i          (sc_ok),
    .addr_i        (req_addr_i),
    .data_i        (req_data_i),
    .st_en_o       (st_en_o),
    .st_addr_o     (st_addr_o),
    .st_data_o     (st_data_o),
    .result_valid_o(result_valid_o),
    .result_o      (result_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_OFF_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_data_i,
  input logic              inv_valid_i,
  input logic [ADDR_W-1:0] inv_addr_i,
  input logic              evict_valid_i,
  input logic [ADDR_W-1:0] evict_addr_i,
  input logic              ctx_switch_i,
  input logic              st_en_o,
  input logic [ADDR_W-1:0] st_addr_o,
  input logic [DATA_W-1:0] st_data_o,
  input logic              result_valid_o,
  input logic [DATA_W-1:0] result_o
);
  logic sc_req;
  assign sc_req = req_valid_i && (req_op_i == OP_SC);

  assert_store_success_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_o |-> (result_valid_o && result_o == DATA_W'(1)));

  assert_store_fwd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_req |=> (st_addr_o == $past(req_addr_i) && st_data_o == $past(req_data_i)));

  assert_fail_no_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && result_o == '0) |-> !st_en_o);

  assert_result_after_sc_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_req |=> result_valid_o);

  assert_no_idle_result_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_req |=> !result_valid_o);

  assert_ctx_fails_sc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_req && ctx_switch_i) |=> (result_valid_o && result_o == '0));

  assert_inv_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_req && inv_valid_i &&
     inv_addr_i[ADDR_W-1:LINE_OFF_W] == req_addr_i[ADDR_W-1:LINE_OFF_W]) |=> !st_en_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LINE_OFF_W(LINE_OFF_W)
) chk_i (.*);

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 4;
  localparam int NVEC   = 37;

  localparam logic [1:0] K_IDLE = 2'd0, K_LL = 2'd1, K_SC = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic        inv;
    logic [15:0] inv_a;
    logic        evc;
    logic [15:0] evc_a;
    logic        ctx;
    logic        ok;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(logic [1:0] k, logic [15:0] a, logic i, logic [15:0] ia,
                              logic e, logic [15:0] ea, logic c, logic ok, logic [7:0] r);
    vec_t v;
    v.kind = k; v.addr = a; v.inv = i; v.inv_a = ia; v.evc = e; v.evc_a = ea;
    v.ctx = c; v.ok = ok; v.req = r;
    return v;
  endfunction

  localparam vec_t VECS [NVEC] = '{
    mk(K_SC,   16'h0100, 0, 0,       0, 0,       0, 0, 3),  // R3 nothing reserved
    mk(K_LL,   16'h0100, 0, 0,       0, 0,       0, 0, 2),
    mk(K_SC,   16'h0104, 0, 0,       0, 0,       0, 1, 4),  // R4 offset ignored, R2
    mk(K_SC,   16'h0100, 0, 0,       0, 0,       0, 0, 5),  // R5 consumed
    mk(K_LL,   16'h0200, 0, 0,       0, 0,       0, 0, 6),
    mk(K_LL,   16'h0300, 0, 0,       0, 0,       0, 0, 6),
    mk(K_SC,   16'h0200, 0, 0,       0, 0,       0, 0, 6),  // R6 old line lost
    mk(K_LL,   16'h0200, 0, 0,       0, 0,       0, 0, 6),
    mk(K_SC,   16'h020C, 0, 0,       0, 0,       0, 1, 6),  // R6 new line wins
    mk(K_LL,   16'h0400, 0, 0,       0, 0,       0, 0, 7),
    mk(K_IDLE, 16'h0000, 1, 16'h0410,0, 0,       0, 0, 7),  // R7 neighbour line
    mk(K_SC,   16'h0400, 0, 0,       0, 0,       0, 1, 7),
    mk(K_LL,   16'h0400, 0, 0,       0, 0,       0, 0, 7),
    mk(K_IDLE, 16'h0000, 1, 16'h0408,0, 0,       0, 0, 7),  // R7 same line
    mk(K_SC,   16'h0400, 0, 0,       0, 0,       0, 0, 7),
    mk(K_LL,   16'h0600, 0, 0,       0, 0,       0, 0, 8),
    mk(K_IDLE, 16'h0000, 0, 0,       1, 16'h05F0,0, 0, 8),  // R8 neighbour line
    mk(K_SC,   16'h0600, 0, 0,       0, 0,       0, 1, 8),
    mk(K_LL,   16'h0600, 0, 0,       0, 0,       0, 0, 8),
    mk(K_IDLE, 16'h0000, 0, 0,       1, 16'h060F,0, 0, 8),  // R8 same line
    mk(K_SC,   16'h0600, 0, 0,       0, 0,       0, 0, 8),
    mk(K_LL,   16'h0800, 0, 0,       0, 0,       0, 0, 9),
    mk(K_IDLE, 16'h0000, 0, 0,       0, 0,       1, 0, 9),  // R9 ctx
    mk(K_SC,   16'h0800, 0, 0,       0, 0,       0, 0, 9),
    mk(K_LL,   16'h0800, 0, 0,       0, 0,       0, 0, 10),
    mk(K_SC,   16'h0800, 1, 16'h0804,0, 0,       0, 0, 10), // R10 race lost
    mk(K_LL,   16'h0900, 0, 0,       0, 0,       0, 0, 10),
    mk(K_SC,   16'h0900, 1, 16'h0A00,0, 0,       0, 1, 10), // R10 other line
    mk(K_LL,   16'h0A00, 1, 16'h0A04,0, 0,       0, 0, 11), // R11 inv with LL
    mk(K_SC,   16'h0A00, 0, 0,       0, 0,       0, 0, 11),
    mk(K_LL,   16'h0B00, 0, 0,       1, 16'h0C00,0, 0, 11), // R11 other line
    mk(K_SC,   16'h0B00, 0, 0,       0, 0,       0, 1, 11),
    mk(K_LL,   16'h0D00, 0, 0,       0, 0,       0, 0, 3),
    mk(K_SC,   16'h0E00, 0, 0,       0, 0,       0, 0, 3),  // R3 wrong line
    mk(K_SC,   16'h0D00, 0, 0,       0, 0,       0, 0, 5),  // R5 failed sc consumed
    mk(K_LL,   16'h0F00, 0, 0,       0, 0,       0, 0, 9),
    mk(K_SC,   16'h0F00, 0, 0,       0, 0,       1, 0, 9)   // R9 ctx same cycle
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_op_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_data_i = '0;
  logic              inv_valid_i = 1'b0;
  logic [ADDR_W-1:0] inv_addr_i = '0;
  logic              evict_valid_i = 1'b0;
  logic [ADDR_W-1:0] evict_addr_i = '0;
  logic              ctx_switch_i = 1'b0;
  logic              st_en_o;
  logic [ADDR_W-1:0] st_addr_o;
  logic [DATA_W-1:0] st_data_o;
  logic              result_valid_o;
  logic [DATA_W-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  llsc_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFF_W(OFF_W)) dut_i (.*);

  function automatic logic [DATA_W-1:0] data_of(logic [15:0] a);
    return {16'hA5A5, a ^ 16'h3C3C};
  endfunction

  task automatic drive(vec_t v);
    req_valid_i   = (v.kind != K_IDLE);
    req_op_i      = (v.kind == K_SC);
    req_addr_i    = ADDR_W'(v.addr);
    req_data_i    = data_of(v.addr);
    inv_valid_i   = v.inv;
    inv_addr_i    = ADDR_W'(v.inv_a);
    evict_valid_i = v.evc;
    evict_addr_i  = ADDR_W'(v.evc_a);
    ctx_switch_i  = v.ctx;
  endtask

  task automatic check_out(int rq, logic ev, logic es, logic [DATA_W-1:0] er,
                           logic [ADDR_W-1:0] ea, logic [DATA_W-1:0] ed);
    logic bad;
    n_chk++;
    bad = (result_valid_o !== ev) || (st_en_o !== es);
    if (ev) bad = bad || (result_o !== er);
    if (es) bad = bad || (st_addr_o !== ea) || (st_data_o !== ed);
    if (bad) begin
      n_bad++;
      $display("FAIL R%0d: got valid=%b st_en=%b res=%0h addr=%0h data=%0h exp valid=%b st_en=%b res=%0h addr=%0h data=%0h",
               rq, result_valid_o, st_en_o, result_o, st_addr_o, st_data_o, ev, es, er, ea, ed);
    end
  endtask

  initial begin
    vec_t idle;
    idle = mk(K_IDLE, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    check_out(1, 1'b0, 1'b0, '0, '0, '0);  // R1 outputs idle in reset
    rst_ni = 1'b1;

    // R12 checked on every vector through valid/st_en expectation
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      check_out(int'(VECS[i].req), VECS[i].kind == K_SC, VECS[i].ok,
                DATA_W'(VECS[i].ok), ADDR_W'(VECS[i].addr), data_of(VECS[i].addr));
    end

    // R1: reset kills a live reservation
    drive(mk(K_LL, 16'h1230, 0, 0, 0, 0, 0, 0, 1));
    @(negedge clk_i);
    drive(idle);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_out(1, 1'b0, 1'b0, '0, '0, '0);
    rst_ni = 1'b1;
    drive(mk(K_SC, 16'h1230, 0, 0, 0, 0, 0, 0, 1));
    @(negedge clk_i);
    check_out(1, 1'b1, 1'b0, '0, '0, '0);

    // R12: back-to-back LL/SC, then idle cycle drops the result strobe
    drive(mk(K_LL, 16'h2000, 0, 0, 0, 0, 0, 0, 12));
    @(negedge clk_i);
    check_out(12, 1'b0, 1'b0, '0, '0, '0);
    drive(mk(K_SC, 16'h200F, 0, 0, 0, 0, 0, 0, 2));
    @(negedge clk_i);
    check_out(2, 1'b1, 1'b1, DATA_W'(1), ADDR_W'(16'h200F), data_of(16'h200F));
    drive(idle);
    @(negedge clk_i);
    check_out(12, 1'b0, 1'b0, '0, '0, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule